// File: doc/BRIEF.md
# Programmable Countdown Waveform Timer

This block is a down-counting timer that shapes one output pin. A host loads a 14-bit count value and then writes a control word. The control word holds a 2-bit waveform mode and a 2-bit command. The counter moves by one on each system clock edge where the timer enable input `tick` is high. Each time the counter reaches its terminal count, the block applies the selected mode. It can produce a single square wave, a continuous square wave, a single low pulse or a repeating low pulse.

The command part of the control word acts once, on the write that carries it. It can stop the timer at once, or stop it at the next terminal count. It can also start the timer, or ask for the new count value to be taken up at the next terminal count. The host sees whether the timer is running and a sticky terminal-count flag. A status-read strobe clears that flag. The output rests high whenever the timer is stopped.

Top module: `wavetimer`

## Requirements
- R1: After reset the timer is stopped, `tmr_out` is 1 and `tc_flag` is 0. The count register and mode field are cleared, so a later start with no count write runs with an effective count of 2.
- R2: With `wr_en`=1 and `wr_sel`=0, the count register takes `wr_data[13:0]`. With `wr_sel`=1, the mode is taken from `wr_data[1:0]` (00 single square, 01 continuous square, 10 single pulse, 11 repeating pulse) and the command from `wr_data[3:2]`. Command 00 leaves the run state unchanged.
- R3: Command 11 given while stopped sets `running` one clock after the write. The counter is loaded with the effective count and the waveform restarts from its beginning.
- R4: Command 01 clears `running` one clock after the write and returns `tmr_out` to 1. Given while stopped, it has no effect.
- R5: Command 10 given while running lets the current period finish, then stops the timer at the next terminal count.
- R6: Writing the count register alone does not change the period of a running timer. Command 11 given while running makes the new count take effect from the next terminal count on.
- R7: In mode 01 with an even count N, `tmr_out` is high for N/2 ticks and low for N/2 ticks, repeating.
- R8: With an odd count N, the square wave is high for (N+1)/2 ticks and low for (N-1)/2 ticks.
- R9: Mode 00 produces one square-wave period and then stops, leaving `tmr_out` high.
- R10: Mode 10 drives `tmr_out` low for exactly the single tick interval that ends at the N-th tick, then stops.
- R11: Mode 11 drives `tmr_out` low for one tick interval in every N ticks, repeating without end.
- R12: A count value of 0 or 1 is run as 2.
- R13: `tc_flag` sets at every terminal count and stays set until `stat_rd` is pulsed. If a terminal count and `stat_rd` fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer count enable, one count per clock where high |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 selects count register, 1 selects control word |
| wr_data | input | 14 | Host write data |
| stat_rd | input | 1 | Status read strobe, clears the terminal-count flag |
| tmr_out | output | 1 | Waveform output, idles high |
| running | output | 1 | Timer running status |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
Every result here is due exactly one clock after the edge that samples its stimulus: a host write, a single-cycle `tick` or a `stat_rd` strobe. No input reaches an output without passing through a register first. The driver applies each stimulus on a falling edge, updates an independent position-based model of the waveform, and queues the expected output, run and flag values tagged with the cycle number at which they are due. The monitor compares them on the falling edge after that rising edge, so every sample lands one full clock after the change. Long runs of ticks walk whole periods of each mode, including the odd-count split, the clamping of counts below 2, and the timing of the stop-after-terminal and reload commands.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_MODE_LSB = 0;
    localparam int TMR_CMD_LSB  = 2;

    typedef enum logic [1:0] {
        MODE_SQ_ONCE = 2'b00,
        MODE_SQ_CONT = 2'b01,
        MODE_PL_ONCE = 2'b10,
        MODE_PL_CONT = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_HALT    = 2'b01,
        CMD_HALT_TC = 2'b10,
        CMD_GO      = 2'b11
    } tmr_cmd_e;

    typedef struct packed {
        logic     valid;
        tmr_cmd_e cmd;
    } ctl_req_t;

    function automatic logic is_single(input tmr_mode_e m);
        return (m == MODE_SQ_ONCE) || (m == MODE_PL_ONCE);
    endfunction

    function automatic logic is_pulse(input tmr_mode_e m);
        return (m == MODE_PL_ONCE) || (m == MODE_PL_CONT);
    endfunction

endpackage

// File: rtl/wt_host.sv
module wt_host
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int MIN_CNT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tc_evt,
    input  logic             stat_rd,
    output tmr_mode_e        mode,
    output ctl_req_t         req,
    output logic [CNT_W-1:0] eff_cnt,
    output logic             tc_flag
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);

    logic [CNT_W-1:0] cnt_q;
    tmr_mode_e        mode_q;
    logic             flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= MODE_SQ_ONCE;
            flag_q <= 1'b0;
        end else begin
            if (wr_en && !wr_sel)
                cnt_q <= wr_data;
            if (wr_en && wr_sel)
                mode_q <= tmr_mode_e'(wr_data[TMR_MODE_LSB +: 2]);
            if (tc_evt)
                flag_q <= 1'b1;
            else if (stat_rd)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        req.valid = wr_en && wr_sel;
        req.cmd   = tmr_cmd_e'(wr_data[TMR_CMD_LSB +: 2]);
        eff_cnt   = (cnt_q < MIN_V) ? MIN_V : cnt_q;
    end

    assign mode    = mode_q;
    assign tc_flag = flag_q;

    assert_flag_set_R13: assert property (@(posedge clk) disable iff (rst)
        tc_evt |=> tc_flag);
    assert_flag_clear_R13: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !tc_evt) |=> !tc_flag);
endmodule

// File: rtl/wt_count.sv
module wt_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ctl_req_t         req,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] eff_cnt,
    output logic             running,
    output logic [CNT_W-1:0] remain,
    output logic [CNT_W-1:0] period,
    output logic             tc_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             run_q, stop_pend, reload_pend;
    logic [CNT_W-1:0] rem_q, per_q;
    logic             halt_now, go_idle;

    always_comb begin
        halt_now = req.valid && (req.cmd == CMD_HALT);
        go_idle  = req.valid && (req.cmd == CMD_GO) && !run_q;
        tc_evt   = run_q && tick && (rem_q == ONE) && !halt_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= 1'b0;
            stop_pend   <= 1'b0;
            reload_pend <= 1'b0;
            rem_q       <= '0;
            per_q       <= '0;
        end else if (halt_now) begin
            run_q       <= 1'b0;
            stop_pend   <= 1'b0;
            reload_pend <= 1'b0;
        end else if (go_idle) begin
            run_q       <= 1'b1;
            per_q       <= eff_cnt;
            rem_q       <= eff_cnt;
            stop_pend   <= 1'b0;
            reload_pend <= 1'b0;
        end else begin
            if (tc_evt) begin
                if (reload_pend) begin
                    per_q <= eff_cnt;
                    rem_q <= eff_cnt;
                end else begin
                    rem_q <= per_q;
                end
                reload_pend <= 1'b0;
                stop_pend   <= 1'b0;
                if (is_single(mode) || stop_pend)
                    run_q <= 1'b0;
            end else if (run_q && tick) begin
                rem_q <= rem_q - ONE;
            end
            if (req.valid && run_q && (req.cmd == CMD_HALT_TC))
                stop_pend <= 1'b1;
            if (req.valid && run_q && (req.cmd == CMD_GO))
                reload_pend <= 1'b1;
        end
    end

    assign running = run_q;
    assign remain  = rem_q;
    assign period  = per_q;

    assert_remain_range_R3: assert property (@(posedge clk) disable iff (rst)
        running |-> (remain != '0) && (remain <= period));
    assert_period_min_R12: assert property (@(posedge clk) disable iff (rst)
        running |-> (period > ONE));
    assert_halt_now_R4: assert property (@(posedge clk) disable iff (rst)
        halt_now |=> !running);
    assert_go_load_R3: assert property (@(posedge clk) disable iff (rst)
        go_idle |=> running && (remain == period));
endmodule

// File: rtl/wt_wave.sv
module wt_wave
    import tmr_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             running,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] remain,
    input  logic [CNT_W-1:0] period,
    output logic             wave
);
    logic [CNT_W-1:0] half;
    logic             sq_hi, pl_hi;

    always_comb begin
        half  = period >> 1;
        sq_hi = remain > half;
        pl_hi = remain != CNT_W'(1);
        wave  = !running || (is_pulse(mode) ? pl_hi : sq_hi);
    end
endmodule

// File: rtl/wavetimer.sv
module wavetimer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int MIN_CNT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             stat_rd,
    output logic             tmr_out,
    output logic             running,
    output logic             tc_flag
);
    tmr_mode_e        mode;
    ctl_req_t         req;
    logic [CNT_W-1:0] eff_cnt, remain, period;
    logic             tc_evt;

    wt_host #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_host (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tc_evt(tc_evt), .stat_rd(stat_rd),
        .mode(mode), .req(req), .eff_cnt(eff_cnt), .tc_flag(tc_flag)
    );

    wt_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .tick(tick), .req(req), .mode(mode),
        .eff_cnt(eff_cnt), .running(running), .remain(remain),
        .period(period), .tc_evt(tc_evt)
    );

    wt_wave #(.CNT_W(CNT_W)) u_wave (
        .running(running), .mode(mode), .remain(remain),
        .period(period), .wave(tmr_out)
    );

    assert_single_stops_R9: assert property (@(posedge clk) disable iff (rst)
        (tc_evt && is_single(mode)) |=> !running);
    assert_idle_after_tc_R10: assert property (@(posedge clk) disable iff (rst)
        (tc_evt && is_single(mode)) |=> tmr_out);
endmodule

// File: tb/sim_wavetimer.sv
module sim_wavetimer;
    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, stat_rd = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic          tmr_out, running, tc_flag;

    always #10 clk = ~clk;

    wavetimer u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .stat_rd(stat_rd), .tmr_out(tmr_out),
        .running(running), .tc_flag(tc_flag)
    );

    typedef struct {
        int    due;
        logic  out;
        logic  run;
        logic  flag;
        string req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0, errors = 0;
    bit   done = 0;

    // reference model, position-based
    bit       m_run, m_stop, m_reload, m_flag;
    int       m_pos, m_tc, m_cnt;
    bit [1:0] m_mode;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff(input int c);
        return (c < 2) ? 2 : c;
    endfunction

    function automatic logic m_out();
        if (!m_run) return 1'b1;
        if (m_mode[1]) return (m_pos != m_tc - 1);
        return (m_pos < (m_tc + 1) / 2);
    endfunction

    task automatic push(input string r);
        exp_t e;
        e.due = cyc + 1; e.out = m_out(); e.run = m_run; e.flag = m_flag; e.req = r;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (tmr_out !== e.out || running !== e.run || tc_flag !== e.flag) begin
                errors++;
                $display("FAIL %s cyc %0d: out/run/flag actual %b%b%b expected %b%b%b",
                         e.req, cyc, tmr_out, running, tc_flag, e.out, e.run, e.flag);
            end
        end
    end

    task automatic do_reset(input string r);
        @(negedge clk);
        rst = 1'b1;
        m_run = 0; m_stop = 0; m_reload = 0; m_flag = 0;
        m_pos = 0; m_tc = 2; m_cnt = 0; m_mode = 2'b00;
        @(negedge clk);
        push(r);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_count(input int v, input string r);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = CW'(v);
        m_cnt = v;
        push(r);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ctl(input bit [1:0] cmd, input bit [1:0] mode, input string r);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = CW'({cmd, mode});
        m_mode = mode;
        case (cmd)
            2'b01: begin m_run = 0; m_stop = 0; m_reload = 0; end
            2'b10: if (m_run) m_stop = 1;
            2'b11: if (!m_run) begin
                       m_run = 1; m_tc = eff(m_cnt); m_pos = 0; m_stop = 0; m_reload = 0;
                   end else m_reload = 1;
            default: ;
        endcase
        push(r);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n, input string r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            if (m_run) begin
                m_pos++;
                if (m_pos == m_tc) begin
                    m_pos = 0; m_flag = 1;
                    if (m_reload) m_tc = eff(m_cnt);
                    m_reload = 0;
                    if (!m_mode[0] || m_stop) m_run = 0;
                    m_stop = 0;
                end
            end
            push(r);
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic read_stat(input string r);
        @(negedge clk);
        stat_rd = 1'b1;
        m_flag = 0;
        push(r);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        do_reset("R1");
        ticks(2, "R1");
        // R7 even continuous square
        wr_count(6, "R2");
        wr_ctl(2'b11, 2'b01, "R3");
        ticks(13, "R7");
        read_stat("R13");
        ticks(1, "R13");
        // R4 stop now, and no effect when stopped
        wr_ctl(2'b01, 2'b01, "R4");
        wr_ctl(2'b01, 2'b01, "R4");
        ticks(2, "R4");
        // R8 odd split
        wr_count(5, "R2");
        wr_ctl(2'b11, 2'b01, "R3");
        ticks(11, "R8");
        wr_ctl(2'b00, 2'b01, "R2");
        ticks(2, "R2");
        wr_ctl(2'b01, 2'b01, "R4");
        // R9 single square
        wr_count(4, "R2");
        wr_ctl(2'b11, 2'b00, "R9");
        ticks(6, "R9");
        // R10 single pulse
        wr_count(3, "R2");
        wr_ctl(2'b11, 2'b10, "R10");
        ticks(5, "R10");
        // R11 repeating pulse
        wr_ctl(2'b11, 2'b11, "R11");
        ticks(8, "R11");
        wr_ctl(2'b01, 2'b11, "R4");
        // R12 counts below 2
        wr_count(1, "R12");
        wr_ctl(2'b11, 2'b11, "R12");
        ticks(5, "R12");
        wr_ctl(2'b01, 2'b01, "R4");
        wr_count(0, "R12");
        wr_ctl(2'b11, 2'b01, "R12");
        ticks(4, "R12");
        wr_ctl(2'b01, 2'b01, "R4");
        // R5 stop after terminal count
        wr_count(4, "R2");
        wr_ctl(2'b11, 2'b01, "R3");
        ticks(1, "R5");
        wr_ctl(2'b10, 2'b01, "R5");
        ticks(5, "R5");
        // R6 count write alone ignored, reload via command
        wr_ctl(2'b11, 2'b11, "R3");
        ticks(1, "R6");
        wr_count(2, "R6");
        ticks(4, "R6");
        wr_ctl(2'b11, 2'b11, "R6");
        ticks(7, "R6");
        read_stat("R13");
        ticks(1, "R13");
        // R1 reset mid-run clears count and mode
        do_reset("R1");
        wr_ctl(2'b11, 2'b11, "R1");
        ticks(4, "R1");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end
endmodule